// File: doc/BRIEF.md
# DMA Address Sequencer with Chunk Rewind

This block generates the byte addresses for the two sides of a DMA channel. Lane 0 serves the read (source) side and lane 1 serves the write (destination) side. Each lane has its own settings. Software-visible logic writes a 64-bit start address into a lane, one 32-bit half at a time. Any such write also moves that lane's current address to the updated start value.

Each lane has two mode flags and a stride in bytes. While its beat strobe is high, the lane either keeps its address or adds the stride to it. While its chunk-end strobe is high, a lane in rewind mode jumps back to its start address. The surrounding channel logic supplies both strobes and reads the registered address output. Bus handshakes, data movement and byte counting all stay outside this block.

Top module: `dma_addr_pair`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, both lanes' start value and address output are zero.
- R2: A low-half write (`lo_we_i[n]`) puts `half_i[n]` into bits [31:0] of lane n's start value and keeps bits [63:32]. From the next cycle, `addr_o[n]` equals the new start value.
- R3: A high-half write (`hi_we_i[n]`) puts `half_i[n]` into bits [63:32] of the start value and keeps bits [31:0]. From the next cycle, `addr_o[n]` equals the new start value. If both write strobes are high in one cycle, `half_i[n]` goes into both halves.
- R4: Fixed mode is selected when `inc_i[n]`=0, whatever the value of `wrap_i[n]`. In fixed mode, beat and chunk-end strobes leave `addr_o[n]` unchanged.
- R5: Linear mode is selected when `inc_i[n]`=1 and `wrap_i[n]`=0. Each cycle with `beat_i[n]`=1 adds `stride_i[n]` (unsigned, in bytes) to `addr_o[n]`, modulo 2^64, with a carry into the upper half. A chunk end has no effect in this mode.
- R6: Rewind mode is selected when `inc_i[n]`=1 and `wrap_i[n]`=1. Beats advance the address by the stride. A cycle with `chunk_end_i[n]`=1 sets `addr_o[n]` back to the start value in the next cycle.
- R7: In rewind mode, if a beat and a chunk end fall in the same cycle, the next address is the start value and not the advanced address.
- R8: A half write in the same cycle as a beat or a chunk end takes priority. The next address is the newly written start value.
- R9: The two lanes are independent. Strobes, writes and settings of one lane never change the other lane's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lo_we_i | input | 2 | Per-lane strobe to write the low half of the start value |
| hi_we_i | input | 2 | Per-lane strobe to write the high half of the start value |
| half_i | input | 2x32 | Per-lane half-word data for the start value |
| inc_i | input | 2 | Per-lane advance flag |
| wrap_i | input | 2 | Per-lane rewind flag (only used when advance is set) |
| stride_i | input | 2x4 | Per-lane advance per beat, in bytes |
| beat_i | input | 2 | Per-lane beat-accepted strobe |
| chunk_end_i | input | 2 | Per-lane chunk-complete strobe |
| addr_o | output | 2x64 | Per-lane current address (registered) |

## Verification
The critical collision is the last beat of a chunk: its beat strobe and its chunk-end strobe arrive in the same cycle. Rewind mode must then return to the start address, while linear mode must still add the stride. The bench drives this collision directly in both modes. It also repeats it through random strobes on both lanes together with the second collision, a half write landing on a beat. A behavioural model applies the stated priority order (write, then rewind, then advance) and judges every lane on every clock.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic [1:0] {
    AG_FIXED  = 2'd0,
    AG_LINEAR = 2'd1,
    AG_REWIND = 2'd2
  } ag_mode_e;

  typedef enum logic [1:0] {
    EV_HOLD   = 2'd0,
    EV_STEP   = 2'd1,
    EV_REWIND = 2'd2,
    EV_LOAD   = 2'd3
  } ag_event_e;

  // Clearing the advance flag always gives fixed mode, whatever the rewind flag says.
  function automatic ag_mode_e ag_decode(input logic inc, input logic wrap);
    if (!inc) return AG_FIXED;
    if (wrap) return AG_REWIND;
    return AG_LINEAR;
  endfunction

  // Priority: a start write beats a rewind, and a rewind beats an advance.
  function automatic ag_event_e ag_pick(input logic load, input ag_mode_e mode,
                                        input logic beat, input logic chunk);
    if (load) return EV_LOAD;
    if (mode == AG_REWIND && chunk) return EV_REWIND;
    if (mode != AG_FIXED && beat) return EV_STEP;
    return EV_HOLD;
  endfunction

endpackage

// File: rtl/dma_ag_start.sv
module dma_ag_start #(
  parameter int HALF_W = 32,
  localparam int ADDR_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [ADDR_W-1:0] start_q_o,
  output logic [ADDR_W-1:0] start_nxt_o,
  output logic              load_o
);

  logic [ADDR_W-1:0] start_q;

  always_comb begin
    start_nxt_o = start_q;
    if (lo_we_i) start_nxt_o[HALF_W-1:0]      = half_i;
    if (hi_we_i) start_nxt_o[ADDR_W-1:HALF_W] = half_i;
  end

  assign load_o    = lo_we_i | hi_we_i;
  assign start_q_o = start_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) start_q <= '0;
    else         start_q <= start_nxt_o;
  end

  // R2
  lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !hi_we_i) |=> start_q_o[ADDR_W-1:HALF_W] == $past(start_q_o[ADDR_W-1:HALF_W]));
  // R3
  hi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !lo_we_i) |=> start_q_o[HALF_W-1:0] == $past(start_q_o[HALF_W-1:0]));

endmodule

// File: rtl/dma_ag_advance.sv
module dma_ag_advance
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int STRIDE_W = 4
) (
  input  logic [ADDR_W-1:0]   cur_i,
  input  logic [ADDR_W-1:0]   start_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  ag_event_e           ev_i,
  output logic [ADDR_W-1:0]   nxt_o
);

  function automatic logic [ADDR_W-1:0] add_stride(input logic [ADDR_W-1:0] a,
                                                   input logic [STRIDE_W-1:0] s);
    return a + ADDR_W'(s);
  endfunction

  always_comb begin
    unique case (ev_i)
      EV_LOAD, EV_REWIND: nxt_o = start_i;
      EV_STEP:            nxt_o = add_stride(cur_i, stride_i);
      default:            nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/dma_ag_lane.sv
module dma_ag_lane
  import dma_ag_pkg::*;
#(
  parameter int HALF_W   = 32,
  parameter int STRIDE_W = 4,
  localparam int ADDR_W  = 2 * HALF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic [HALF_W-1:0]   half_i,
  input  logic                inc_i,
  input  logic                wrap_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                beat_i,
  input  logic                chunk_end_i,
  output logic [ADDR_W-1:0]   addr_o
);

  logic [ADDR_W-1:0] start_q, start_nxt, addr_q, addr_nxt;
  logic              load;
  ag_mode_e          mode;
  ag_event_e         ev;

  dma_ag_start #(.HALF_W(HALF_W)) u_start (
    .clk_i, .rst_ni, .lo_we_i, .hi_we_i, .half_i,
    .start_q_o(start_q), .start_nxt_o(start_nxt), .load_o(load)
  );

  assign mode = ag_decode(inc_i, wrap_i);
  assign ev   = ag_pick(load, mode, beat_i, chunk_end_i);

  dma_ag_advance #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_adv (
    .cur_i(addr_q), .start_i(start_nxt), .stride_i, .ev_i(ev), .nxt_o(addr_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_nxt;
  end

  assign addr_o = addr_q;

  // R2
  lo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> addr_o[HALF_W-1:0] == $past(half_i));
  // R3
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> addr_o[ADDR_W-1:HALF_W] == $past(half_i));
  // R4
  fixed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !inc_i) |=> $stable(addr_o));
  // R5
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && inc_i && !wrap_i && beat_i) |=> addr_o == $past(addr_o) + ADDR_W'($past(stride_i)));
  // R6
  rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && inc_i && wrap_i && chunk_end_i) |=> addr_o == start_q);
  // R7
  rewind_over_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && inc_i && wrap_i && chunk_end_i && beat_i) |=> addr_o == start_q);
  // R8
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && (beat_i || chunk_end_i)) |=> addr_o == start_q);

endmodule

// File: rtl/dma_addr_pair.sv
module dma_addr_pair #(
  parameter int HALF_W   = 32,
  parameter int STRIDE_W = 4,
  localparam int ADDR_W  = 2 * HALF_W,
  localparam int NLANE   = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NLANE-1:0]                lo_we_i,
  input  logic [NLANE-1:0]                hi_we_i,
  input  logic [NLANE-1:0][HALF_W-1:0]    half_i,
  input  logic [NLANE-1:0]                inc_i,
  input  logic [NLANE-1:0]                wrap_i,
  input  logic [NLANE-1:0][STRIDE_W-1:0]  stride_i,
  input  logic [NLANE-1:0]                beat_i,
  input  logic [NLANE-1:0]                chunk_end_i,
  output logic [NLANE-1:0][ADDR_W-1:0]    addr_o
);

  for (genvar n = 0; n < NLANE; n++) begin : g_lane
    dma_ag_lane #(.HALF_W(HALF_W), .STRIDE_W(STRIDE_W)) u_lane (
      .clk_i, .rst_ni,
      .lo_we_i(lo_we_i[n]), .hi_we_i(hi_we_i[n]), .half_i(half_i[n]),
      .inc_i(inc_i[n]), .wrap_i(wrap_i[n]), .stride_i(stride_i[n]),
      .beat_i(beat_i[n]), .chunk_end_i(chunk_end_i[n]), .addr_o(addr_o[n])
    );
  end

  // R9
  lane_isolation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_we_i[1] && !hi_we_i[1] && !beat_i[1] && !chunk_end_i[1]) |=> $stable(addr_o[1]));

endmodule

// File: tb/dma_addr_pair_test.sv
module dma_addr_pair_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] lo_we = '0, hi_we = '0, inc = '0, wrap = '0, beat = '0, chunk = '0;
  logic [1:0][31:0] half = '0;
  logic [1:0][3:0]  stride = '0;
  logic [1:0][63:0] addr;

  always #4 clk = ~clk;

  dma_addr_pair uut (
    .clk_i(clk), .rst_ni(rst_ni), .lo_we_i(lo_we), .hi_we_i(hi_we), .half_i(half),
    .inc_i(inc), .wrap_i(wrap), .stride_i(stride), .beat_i(beat), .chunk_end_i(chunk),
    .addr_o(addr)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  longint unsigned st [2];
  longint unsigned cur [2];
  string tag [2];

  task automatic check_lane(input int n);
    checks++;
    if (addr[n] !== cur[n]) begin
      fails++;
      $display("FAIL %s lane %0d: addr=%h expected=%h", tag[n], n, addr[n], cur[n]);
    end
  endtask

  // Reference: a write wins, then a chunk rewind in rewind mode, then a beat advance.
  task automatic model_lane(input int n);
    if (lo_we[n] || hi_we[n]) begin
      if (lo_we[n]) st[n][31:0]  = half[n];
      if (hi_we[n]) st[n][63:32] = half[n];
      cur[n] = st[n];
      tag[n] = (beat[n] || chunk[n]) ? "R8" : (hi_we[n] ? "R3" : "R2");
    end else if (inc[n] && wrap[n] && chunk[n]) begin
      cur[n] = st[n];
      tag[n] = beat[n] ? "R7" : "R6";
    end else if (inc[n] && beat[n]) begin
      cur[n] = cur[n] + longint'(stride[n]);
      tag[n] = wrap[n] ? "R6" : "R5";
    end else if (beat[n] || chunk[n]) begin
      tag[n] = inc[n] ? "R5" : "R4";
    end else begin
      tag[n] = "R9";
    end
  endtask

  task automatic cycle();
    for (int n = 0; n < 2; n++) model_lane(n);
    @(negedge clk);
    for (int n = 0; n < 2; n++) check_lane(n);
    lo_we = '0; hi_we = '0; beat = '0; chunk = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 2; n++) begin st[n] = 0; cur[n] = 0; end
    repeat (3) @(negedge clk);
    tag[0] = "R1"; tag[1] = "R1";
    check_lane(0); check_lane(1);
    rst_ni = 1'b1;
    @(negedge clk);
    check_lane(0); check_lane(1);

    // R2: low-half write on lane 0 while lane 1 stays quiet (R9)
    lo_we[0] = 1; half[0] = 32'h0000_1000; cycle();
    // R5: linear steps of 4, then a chunk end that must do nothing
    inc[0] = 1; wrap[0] = 0; stride[0] = 4;
    repeat (5) begin beat[0] = 1; cycle(); end
    chunk[0] = 1; cycle();
    beat[0] = 1; chunk[0] = 1; cycle();
    // R6: rewind mode
    wrap[0] = 1;
    repeat (3) begin beat[0] = 1; cycle(); end
    chunk[0] = 1; cycle();
    // R7: beat and chunk end in the same cycle
    beat[0] = 1; cycle(); beat[0] = 1; cycle();
    beat[0] = 1; chunk[0] = 1; cycle();
    // R4: fixed mode with the rewind flag set
    inc[0] = 0; beat[0] = 1; cycle(); beat[0] = 1; chunk[0] = 1; cycle();
    // R3: high-half write, then both halves in one cycle
    hi_we[0] = 1; half[0] = 32'hDEAD_BEEF; cycle();
    lo_we[0] = 1; hi_we[0] = 1; half[0] = 32'h1234_5678; cycle();
    // R8: write together with beat and chunk end
    inc[0] = 1; wrap[0] = 1; stride[0] = 8; beat[0] = 1; cycle();
    lo_we[0] = 1; half[0] = 32'h0000_0040; beat[0] = 1; chunk[0] = 1; cycle();
    // R5: carry out of the low half and 64-bit rollover
    wrap[0] = 0;
    lo_we[0] = 1; hi_we[0] = 1; half[0] = 32'hFFFF_FFFC; cycle();
    beat[0] = 1; cycle(); beat[0] = 1; cycle();
    // R9: lane 1 active, lane 0 quiet
    lo_we[1] = 1; half[1] = 32'h8000_0000; cycle();
    inc[1] = 1; wrap[1] = 1; stride[1] = 15;
    repeat (4) begin beat[1] = 1; cycle(); end
    chunk[1] = 1; cycle();
    // Random mix on both lanes
    for (int i = 0; i < 4000; i++) begin
      for (int n = 0; n < 2; n++) begin
        lo_we[n] = ($urandom_range(0, 15) == 0);
        hi_we[n] = ($urandom_range(0, 23) == 0);
        half[n]  = $urandom;
        beat[n]  = $urandom_range(0, 1);
        chunk[n] = ($urandom_range(0, 5) == 0);
        if ($urandom_range(0, 31) == 0) begin
          inc[n] = $urandom_range(0, 1); wrap[n] = $urandom_range(0, 1);
          stride[n] = $urandom_range(0, 15);
        end
      end
      cycle();
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    finish_run();
  end

endmodule